// File: doc/BRIEF.md
# Core Deep-Sleep Entry and Cache Flush Sequencer

This block decides when a multi-threaded core may enter its deep sleep state and prepares it. Each thread has an enable bit and a deep-sleep request bit. Once every enabled thread is asking for deep sleep, the sequencer empties the core's caches in a fixed order: instruction cache, then data cache, then mid-level cache. Each flush is a request/done handshake with logic outside this block. When the last flush completes, the block raises its core-sleep output.

A flush that has started always runs to completion. A break event that arrives during the sequence is remembered. It takes effect only when the flush in progress reports done. At that point the remaining flushes are skipped and the core stays awake.

A wake input brings a sleeping core back and sets the core-active status. The applied performance state is frozen while the core sleeps. The performance target can still be written during sleep, and on wake the core takes up the most recent target.

Top module: `csf_sleep_seq`

## Requirements
- R1: After synchronous reset, flush_req is 0, core_sleep is 0, core_active is 1, pst_applied is 0 and the stored performance target is 0.
- R2: While awake and idle, the sequence starts only if at least one thread is enabled and every enabled thread's request bit is 1. Request bits of disabled threads are ignored. flush_req becomes 3'b001 one cycle after the start condition is seen.
- R3: flush_req is one-hot or zero. Bit 0 is the instruction cache, bit 1 the data cache and bit 2 the mid-level cache, issued in that order. Each bit stays high until its own flush_done bit is seen. The next bit rises in the following cycle. Done bits of caches not being flushed are ignored.
- R4: When flush_done[2] is seen with no break pending, the next cycle shows flush_req 0, core_sleep 1 and core_active 0.
- R5: A break during a flush does not drop or change the flush in progress. After that flush's done bit is seen, flush_req goes to 0, the remaining flushes are skipped, core_sleep stays 0 and core_active stays 1.
- R6: A break in the same cycle as a flush's done bit also aborts the rest of the sequence. A break while idle and awake has no effect.
- R7: While core_sleep is 1, a wake pulse gives core_sleep 0 and core_active 1 in the next cycle.
- R8: The performance target can be written at any time. While awake, pst_applied takes the stored target one cycle after it is written. While sleeping, pst_applied holds. On wake, pst_applied takes the latest stored target.
- R9: A break while core_sleep is 1 has no effect. The core stays asleep until wake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| thr_en | input | NTHR | Per-thread enable |
| thr_deep_req | input | NTHR | Per-thread deep-sleep request |
| brk | input | 1 | Break event pulse |
| wake | input | 1 | Wake pulse for a sleeping core |
| pst_we | input | 1 | Performance-target write strobe |
| pst_wd | input | PST_W | Performance-target write value |
| flush_done | input | 3 | Flush completion strobes (0 I, 1 D, 2 mid-level) |
| flush_req | output | 3 | Flush requests, same bit order |
| core_sleep | output | 1 | Core is in deep sleep |
| core_active | output | 1 | Core-active status |
| pst_applied | output | PST_W | Performance state in force |

## Verification
The assertions assume that all inputs are synchronous to clk and that reset is held for at least one edge. Beyond that they impose nothing: done strobes may arrive for any cache at any time, and breaks and wakes may come in any state. The stimulus holds every input stable from one falling edge to the next. It is otherwise unconstrained: random done bits, breaks, wakes and target writes are mixed in every state, so the ignore rules of R3, R6 and R9 are exercised together with the main path.

// File: rtl/csf_pkg.sv
package csf_pkg;
  localparam int NCACHE = 3;
  typedef enum logic [1:0] {
    SQ_AWAKE = 2'd0,
    SQ_FLUSH = 2'd1,
    SQ_ASLEEP = 2'd2
  } sq_state_t;
endpackage

// File: rtl/csf_entry_gate.sv
module csf_entry_gate #(
  parameter int NTHR = 4
) (
  input  logic [NTHR-1:0] thr_en,
  input  logic [NTHR-1:0] thr_deep_req,
  output logic            all_in
);
  logic [NTHR-1:0] masked;
  always_comb begin
    masked = thr_deep_req & thr_en;
    all_in = (|thr_en) && (masked == thr_en);
  end
endmodule

// File: rtl/csf_flush_seq.sv
module csf_flush_seq
  import csf_pkg::*;
#(
  parameter int NC = NCACHE
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          brk,
  input  logic          wake,
  input  logic [NC-1:0] flush_done,
  output logic [NC-1:0] flush_req,
  output logic          core_sleep,
  output logic          core_active
);
  sq_state_t state;
  logic      brk_pend;
  logic      done_hit;
  logic      last_stage;

  always_comb begin
    done_hit   = |(flush_req & flush_done);
    last_stage = flush_req[NC-1];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= SQ_AWAKE;
      flush_req   <= '0;
      brk_pend    <= 1'b0;
      core_sleep  <= 1'b0;
      core_active <= 1'b1;
    end else begin
      case (state)
        SQ_AWAKE: begin
          brk_pend <= 1'b0;
          if (start) begin
            state     <= SQ_FLUSH;
            flush_req <= {{(NC-1){1'b0}}, 1'b1};
          end
        end
        SQ_FLUSH: begin
          if (done_hit) begin
            brk_pend <= 1'b0;
            if (brk_pend || brk) begin
              state     <= SQ_AWAKE;
              flush_req <= '0;
            end else if (last_stage) begin
              state       <= SQ_ASLEEP;
              flush_req   <= '0;
              core_sleep  <= 1'b1;
              core_active <= 1'b0;
            end else begin
              flush_req <= flush_req << 1;
            end
          end else if (brk) begin
            brk_pend <= 1'b1;
          end
        end
        SQ_ASLEEP: begin
          if (wake) begin
            state       <= SQ_AWAKE;
            core_sleep  <= 1'b0;
            core_active <= 1'b1;
          end
        end
        default: begin
          state     <= SQ_AWAKE;
          flush_req <= '0;
        end
      endcase
    end
  end

  AST_REQ_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(flush_req)); // R3
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
    (flush_req != '0 && (flush_req & flush_done) == '0) |=> flush_req == $past(flush_req)); // R5
  AST_SLEEP_QUIET: assert property (@(posedge clk) disable iff (rst)
    core_sleep |-> (flush_req == '0 && !core_active)); // R4
  AST_WAKE_UP: assert property (@(posedge clk) disable iff (rst)
    (core_sleep && wake) |=> (!core_sleep && core_active)); // R7
  AST_BRK_ASLEEP: assert property (@(posedge clk) disable iff (rst)
    (core_sleep && !wake) |=> core_sleep); // R9
endmodule

// File: rtl/csf_pstate_hold.sv
module csf_pstate_hold #(
  parameter int PW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [PW-1:0] wd,
  input  logic          sleeping,
  input  logic          wake,
  output logic [PW-1:0] applied
);
  logic [PW-1:0] target;

  always_ff @(posedge clk) begin
    if (rst) begin
      target  <= '0;
      applied <= '0;
    end else begin
      if (we) target <= wd;
      if (!sleeping || wake) applied <= target;
    end
  end

  AST_HOLD_ASLEEP: assert property (@(posedge clk) disable iff (rst)
    (sleeping && !wake) |=> $stable(applied)); // R8
endmodule

// File: rtl/csf_sleep_seq.sv
module csf_sleep_seq
  import csf_pkg::*;
#(
  parameter int NTHR  = 4,
  parameter int PST_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NTHR-1:0]   thr_en,
  input  logic [NTHR-1:0]   thr_deep_req,
  input  logic              brk,
  input  logic              wake,
  input  logic              pst_we,
  input  logic [PST_W-1:0]  pst_wd,
  input  logic [NCACHE-1:0] flush_done,
  output logic [NCACHE-1:0] flush_req,
  output logic              core_sleep,
  output logic              core_active,
  output logic [PST_W-1:0]  pst_applied
);
  logic all_in;

  csf_entry_gate #(.NTHR(NTHR)) u_gate (
    .thr_en       (thr_en),
    .thr_deep_req (thr_deep_req),
    .all_in       (all_in)
  );

  csf_flush_seq #(.NC(NCACHE)) u_seq (
    .clk         (clk),
    .rst         (rst),
    .start       (all_in),
    .brk         (brk),
    .wake        (wake),
    .flush_done  (flush_done),
    .flush_req   (flush_req),
    .core_sleep  (core_sleep),
    .core_active (core_active)
  );

  csf_pstate_hold #(.PW(PST_W)) u_pst (
    .clk      (clk),
    .rst      (rst),
    .we       (pst_we),
    .wd       (pst_wd),
    .sleeping (core_sleep),
    .wake     (wake),
    .applied  (pst_applied)
  );

  AST_START_GATED: assert property (@(posedge clk) disable iff (rst)
    (flush_req == '0 && !core_sleep && !all_in) |=> flush_req == '0); // R2
endmodule

// File: tb/sim_csf_sleep_seq.sv
`timescale 1ns/1ps
module sim_csf_sleep_seq;
  localparam int NT = 4;
  localparam int PW = 4;

  logic          clk = 1'b0;
  logic          rst;
  logic [NT-1:0] thr_en, thr_deep_req;
  logic          brk, wake, pst_we;
  logic [PW-1:0] pst_wd;
  logic [2:0]    flush_done;
  logic [2:0]    flush_req;
  logic          core_sleep, core_active;
  logic [PW-1:0] pst_applied;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done_flag = 0;

  always #2.5 clk = ~clk;

  csf_sleep_seq #(.NTHR(NT), .PST_W(PW)) u0 (
    .clk(clk), .rst(rst), .thr_en(thr_en), .thr_deep_req(thr_deep_req),
    .brk(brk), .wake(wake), .pst_we(pst_we), .pst_wd(pst_wd),
    .flush_done(flush_done), .flush_req(flush_req), .core_sleep(core_sleep),
    .core_active(core_active), .pst_applied(pst_applied)
  );

  // Reference model built from the requirements
  int            m_st;   // 0 awake, 1 flushing, 2 asleep
  logic          m_pend;
  logic [2:0]    m_req;
  logic          m_sleep, m_act;
  logic [PW-1:0] m_tgt, m_app;

  function automatic bit start_ok(input logic [NT-1:0] en, input logic [NT-1:0] rq);
    return (en != '0) && ((en & rq) == en);
  endfunction

  function automatic logic [2:0] next_req(input logic [2:0] r);
    return (r == 3'b001) ? 3'b010 : 3'b100;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_st <= 0; m_pend <= 0; m_req <= 0; m_sleep <= 0; m_act <= 1;
      m_tgt <= 0; m_app <= 0;
    end else begin
      if (pst_we) m_tgt <= pst_wd;
      if (m_st != 2 || wake) m_app <= m_tgt;
      case (m_st)
        0: begin
          m_pend <= 0;
          if (start_ok(thr_en, thr_deep_req)) begin m_st <= 1; m_req <= 3'b001; end
        end
        1: begin
          if ((m_req & flush_done) != 0) begin
            m_pend <= 0;
            if (m_pend || brk) begin m_st <= 0; m_req <= 0; end
            else if (m_req == 3'b100) begin
              m_st <= 2; m_req <= 0; m_sleep <= 1; m_act <= 0;
            end else m_req <= next_req(m_req);
          end else if (brk) m_pend <= 1;
        end
        default: if (wake) begin m_st <= 0; m_sleep <= 0; m_act <= 1; end
      endcase
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  task automatic cmp_all();
    chk("R3 flush_req", flush_req, m_req);
    chk("R4 core_sleep", core_sleep, m_sleep);
    chk("R7 core_active", core_active, m_act);
    chk("R8 pst_applied", pst_applied, m_app);
  endtask

  task automatic clr_pulses();
    brk = 0; wake = 0; pst_we = 0; flush_done = 0;
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
    cmp_all();
    clr_pulses();
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done_flag) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected<150000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rst = 1; thr_en = 0; thr_deep_req = 0; pst_wd = 0; clr_pulses();
    @(negedge clk); @(negedge clk);
    rst = 0;
    // R1 reset values
    chk("R1 flush_req", flush_req, 0);
    chk("R1 core_sleep", core_sleep, 0);
    chk("R1 core_active", core_active, 1);
    chk("R1 pst_applied", pst_applied, 0);

    // R6 break while idle does nothing
    brk = 1; step();
    chk("R6 idle brk", flush_req, 0);

    // R2 enabled threads not all requesting: no start
    thr_en = 4'b0011; thr_deep_req = 4'b1101; step(); step();
    chk("R2 no start", flush_req, 0);
    // R2 disabled thread request bits ignored
    thr_en = 4'b0101; thr_deep_req = 4'b0101; step();
    chk("R2 start", flush_req, 3'b001);
    thr_deep_req = 0;
    // R3 wrong done bits ignored
    flush_done = 3'b110; step();
    chk("R3 held", flush_req, 3'b001);
    flush_done = 3'b001; step();
    chk("R3 to D", flush_req, 3'b010);
    // R5 break mid-flush latched, flush continues
    brk = 1; step();
    chk("R5 not dropped", flush_req, 3'b010);
    flush_done = 3'b010; step();
    chk("R5 aborted", flush_req, 0);
    chk("R5 awake", core_active, 1);
    chk("R5 not asleep", core_sleep, 0);

    // R6 break on same cycle as done
    thr_deep_req = 4'b0101; step(); thr_deep_req = 0;
    flush_done = 3'b001; brk = 1; step();
    chk("R6 same-cycle abort", flush_req, 0);

    // R4 full sequence, R8 target writes around sleep
    pst_we = 1; pst_wd = 4'd5; step(); step();
    chk("R8 applied follows", pst_applied, 5);
    thr_deep_req = 4'b0101; step(); thr_deep_req = 0;
    flush_done = 3'b001; step();
    flush_done = 3'b010; step();
    flush_done = 3'b100; step();
    chk("R4 asleep", core_sleep, 1);
    chk("R4 inactive", core_active, 0);
    pst_we = 1; pst_wd = 4'd9; step(); step();
    chk("R8 frozen", pst_applied, 5);
    // R9 break while asleep ignored
    brk = 1; step();
    chk("R9 still asleep", core_sleep, 1);
    wake = 1; step();
    chk("R7 woke", core_active, 1);
    chk("R8 latest target", pst_applied, 9);

    // random phase
    for (int i = 0; i < 4000; i++) begin
      thr_en = NT'($urandom);
      thr_deep_req = ($urandom % 2) ? thr_en | NT'($urandom % 2) : NT'($urandom);
      flush_done = 3'($urandom) & (($urandom % 3 == 0) ? 3'b111 : 3'b000);
      brk = ($urandom % 12) == 0;
      wake = ($urandom % 6) == 0;
      pst_we = ($urandom % 4) == 0;
      pst_wd = PW'($urandom);
      @(posedge clk); @(negedge clk);
      cmp_all();
    end
    done_flag = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule